// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an asynchronous static RAM that has 19 address bits and a 16-bit bidirectional data bus. The host hands over one word-sized read or write at a time through a valid/ready handshake. The controller then steps the RAM control pins through a timed sequence and reports completion with a one-cycle done pulse. For reads, the captured word comes back on the same pulse. The RAM is selected by two chip enables of opposite polarity, and each of its two byte lanes has its own active-low strobe. A separate drive-enable output steers an external tri-state buffer onto the shared data bus.

Every timing minimum is a parameter in nanoseconds, alongside the clock period. Each one is turned into a whole number of clock cycles at elaboration. For reads, chip select and address are applied first. Output enable and the lane strobes open only for the final part of the access window, because their access time is shorter than the address access time. For writes, a write-enable pulse is formed that never overlaps an address change. A write that follows a read is held off long enough for the RAM to release the bus.

Top module: `asram_lane_ctrl`

## Requirements
- R1: After reset the memory pins are idle: ce1N=1, ce2=0, weN=1, oeN=1, lbN=1, ubN=1, memDoutEn=0, rdDone=0. hostReady is 1.
- R2: A request is accepted on a clock edge where hostValid and hostReady are both 1. hostReady is 1 only while the block is idle. A read then selects the RAM (ce1N=0, ce2=1) with weN=1 for RD cycles, holding hostAddr on memAddr.
- R3: During a read, oeN is low only in the last OE cycles of the RD window. lbN is low in those same cycles if hostMask bit 0 is set, and ubN if hostMask bit 1 is set. Bit 0 governs data bits 7:0 and bit 1 governs bits 15:8.
- R4: At the edge that ends the read window, memDin is captured with unselected lanes forced to zero. The next cycle has rdDone=1 for exactly one cycle with hostReady=0. hostReady returns to 1 in the cycle after that.
- R5: A write drives weN low with the RAM selected for WP cycles, with the lane strobes following hostMask as in R3. It is followed by REC cycles with the RAM deselected, where REC = WC − WP when positive and 0 otherwise. Then rdDone pulses.
- R6: memDoutEn is 1 exactly in the cycles where weN is low, and memDout then carries the accepted write data.
- R7: memAddr changes only at an edge where weN was high in the cycle before.
- R8: A write whose nearest previous masked request was a read waits GAP idle cycles, with the RAM deselected, before its write pulse starts.
- R9: A request with hostMask=00 selects nothing and moves no strobe. It pulses rdDone in the cycle after acceptance, leaves the RAM contents unchanged, and does not affect the R8 gap.
- R10: Each cycle count is ceil(time_ns / CLK_NS), with a floor of 1. The read window RD is the larger of the address access and output-enable counts. The pulse WP is the larger of the pulse-width and data-setup counts. With the defaults (5 ns clock): RD=14, OE=7, WP=7, WC=14, GAP=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostValid | input | 1 | Host request present |
| hostReady | output | 1 | Controller idle, request can be taken |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 19 | Word address |
| hostWdata | input | 16 | Write data |
| hostMask | input | 2 | Lane select, bit 0 = low byte |
| rdData | output | 16 | Captured read word, unselected lanes zero |
| rdDone | output | 1 | One-cycle completion pulse |
| ce1N | output | 1 | Chip enable, active low |
| ce2 | output | 1 | Chip enable, active high |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| lbN | output | 1 | Low-lane strobe, active low |
| ubN | output | 1 | High-lane strobe, active low |
| memAddr | output | 19 | RAM address |
| memDout | output | 16 | Data toward the RAM |
| memDoutEn | output | 1 | Drive enable for the external bus buffer |
| memDin | input | 16 | Data read from the RAM bus |

## Verification
The assertions assume that the host changes hostAddr, hostWrite, hostWdata and hostMask only while hostValid is low or in the cycle where the request is taken. They also assume that memDin reflects the RAM's bus and nothing else. The stimulus raises hostValid only in a cycle where hostReady is already high, and drops it right after acceptance. The RAM model in the bench drives memDin only for lanes whose strobe is low while the chip is selected for a read, and puts a fixed junk pattern on every other lane. This lets the zeroing of unselected lanes be seen at rdData.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_GAP,
    S_WPUL,
    S_WREC,
    S_DONE
  } ctl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sel;       // chip selected
    logic wrPulse;   // write enable active
    logic rdOut;     // output enable active
    logic laneGate;  // lane strobes follow the latched mask
    logic drive;     // controller drives the data bus
    logic load;      // latch the host request
    logic capture;   // sample the RAM bus into rdData
    logic done;      // completion pulse
  } strobe_t;

  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int RD_CYC  = 14,
  parameter int OE_CYC  = 7,
  parameter int WP_CYC  = 7,
  parameter int REC_CYC = 7,
  parameter int GAP_CYC = 6
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    hostValid,
  input  logic    hostWrite,
  input  logic    maskZero,
  output logic    hostReady,
  output strobe_t strb
);

  localparam int MAX_CYC  = maxInt(maxInt(RD_CYC, WP_CYC), maxInt(REC_CYC, GAP_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int OE_START = (RD_CYC > OE_CYC) ? RD_CYC - OE_CYC : 0;
  localparam int REC_LAST = (REC_CYC > 0) ? REC_CYC - 1 : 0;

  ctl_state_t       state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic             prevRead;
  logic             accept, capture;
  logic             selReg, wrReg, rdReg, laneReg, drvReg;
  logic             nSel, nWr, nRd;

  always_comb begin
    nState  = state;
    nCnt    = cnt;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state)
      S_IDLE: if (hostValid) begin
        accept = 1'b1;
        nCnt   = '0;
        if (maskZero)      nState = S_DONE;
        else if (!hostWrite) nState = S_READ;
        else if (prevRead) nState = S_GAP;
        else               nState = S_WPUL;
      end
      S_READ: if (cnt == CNT_W'(RD_CYC - 1)) begin
        capture = 1'b1;
        nState  = S_DONE;
      end else nCnt = cnt + 1'b1;
      S_GAP: if (cnt == CNT_W'(GAP_CYC - 1)) begin
        nState = S_WPUL;
        nCnt   = '0;
      end else nCnt = cnt + 1'b1;
      S_WPUL: if (cnt == CNT_W'(WP_CYC - 1)) begin
        nState = (REC_CYC > 0) ? S_WREC : S_DONE;
        nCnt   = '0;
      end else nCnt = cnt + 1'b1;
      S_WREC: if (cnt == CNT_W'(REC_LAST)) nState = S_DONE;
              else nCnt = cnt + 1'b1;
      S_DONE: nState = S_IDLE;
      default: nState = S_IDLE;
    endcase
  end

  // pin strobes are decoded from the next state so they leave flops
  always_comb begin
    nSel = (nState == S_READ) || (nState == S_WPUL);
    nWr  = (nState == S_WPUL);
    nRd  = (nState == S_READ) && (nCnt >= CNT_W'(OE_START));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      prevRead <= 1'b0;
      selReg   <= 1'b0;
      wrReg    <= 1'b0;
      rdReg    <= 1'b0;
      laneReg  <= 1'b0;
      drvReg   <= 1'b0;
    end else begin
      state   <= nState;
      cnt     <= nCnt;
      selReg  <= nSel;
      wrReg   <= nWr;
      rdReg   <= nRd;
      laneReg <= nWr || nRd;
      drvReg  <= nWr;
      if (capture)               prevRead <= 1'b1;
      else if (nState == S_WPUL) prevRead <= 1'b0;
    end
  end

  assign hostReady = (state == S_IDLE);

  always_comb begin
    strb.sel      = selReg;
    strb.wrPulse  = wrReg;
    strb.rdOut    = rdReg;
    strb.laneGate = laneReg;
    strb.drive    = drvReg;
    strb.load     = accept;
    strb.capture  = capture;
    strb.done     = (state == S_DONE);
  end

  // R9: an empty request finishes next cycle and selects nothing
  assert_empty_mask_R9: assert property (@(posedge clk) disable iff (rst)
    (hostValid && hostReady && maskZero) |=> (strb.done && !strb.sel && !strb.laneGate));

  // R4: done is a single-cycle pulse and the host is held off during it
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    strb.done |=> !strb.done);
  assert_done_not_ready_R4: assert property (@(posedge clk) disable iff (rst)
    strb.done |-> !hostReady);

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                strb,
  input  logic [ADDR_W-1:0]      hostAddr,
  input  logic [DATA_W-1:0]      hostWdata,
  input  logic [DATA_W/8-1:0]    hostMask,
  output logic [DATA_W-1:0]      rdData,
  output logic                   ce1N,
  output logic                   ce2,
  output logic                   weN,
  output logic                   oeN,
  output logic [DATA_W/8-1:0]    laneN,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memDout,
  output logic                   memDoutEn,
  input  logic [DATA_W-1:0]      memDin
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdReg;
  logic [LANES-1:0]  maskReg;
  logic [DATA_W-1:0] laneBits;

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      assign laneBits[g*8 +: 8] = {8{maskReg[g]}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      wdReg   <= '0;
      maskReg <= '0;
      rdData  <= '0;
    end else begin
      if (strb.load) begin
        addrReg <= hostAddr;
        wdReg   <= hostWdata;
        maskReg <= hostMask;
      end
      if (strb.capture) rdData <= memDin & laneBits;
    end
  end

  assign ce1N      = ~strb.sel;
  assign ce2       = strb.sel;
  assign weN       = ~strb.wrPulse;
  assign oeN       = ~strb.rdOut;
  assign laneN     = strb.laneGate ? ~maskReg : '1;
  assign memAddr   = addrReg;
  assign memDout   = wdReg;
  assign memDoutEn = strb.drive;

  // R7: address stays put across any stretch of write enable low
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!weN && $past(!weN)) |-> $stable(memAddr));

  // R6: bus drive only inside a selected write pulse
  assert_drive_in_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    memDoutEn |-> (!weN && !ce1N && ce2 && oeN));

  // R2: output enable only with the chip selected and write enable high
  assert_read_select_R2: assert property (@(posedge clk) disable iff (rst)
    !oeN |-> (weN && !ce1N && ce2));

endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 5,
  parameter int T_ACC_NS   = 70,
  parameter int T_OE_NS    = 35,
  parameter int T_WP_NS    = 35,
  parameter int T_DW_NS    = 30,
  parameter int T_WC_NS    = 70,
  parameter int T_FLOAT_NS = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostValid,
  output logic              hostReady,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [1:0]        hostMask,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone,
  output logic              ce1N,
  output logic              ce2,
  output logic              weN,
  output logic              oeN,
  output logic              lbN,
  output logic              ubN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  localparam int OE_CYC  = nsToCycles(T_OE_NS, CLK_NS);
  localparam int RD_CYC  = maxInt(nsToCycles(T_ACC_NS, CLK_NS), OE_CYC);
  localparam int WP_CYC  = maxInt(nsToCycles(T_WP_NS, CLK_NS), nsToCycles(T_DW_NS, CLK_NS));
  localparam int WC_CYC  = nsToCycles(T_WC_NS, CLK_NS);
  localparam int REC_CYC = (WC_CYC > WP_CYC) ? WC_CYC - WP_CYC : 0;
  localparam int GAP_CYC = nsToCycles(T_FLOAT_NS, CLK_NS);

  strobe_t    strb;
  logic [1:0] laneN;

  asram_ctl #(
    .RD_CYC(RD_CYC), .OE_CYC(OE_CYC), .WP_CYC(WP_CYC),
    .REC_CYC(REC_CYC), .GAP_CYC(GAP_CYC)
  ) uCtl (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostWrite(hostWrite),
    .maskZero(hostMask == 2'b00), .hostReady(hostReady), .strb(strb)
  );

  asram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostMask(hostMask), .rdData(rdData),
    .ce1N(ce1N), .ce2(ce2), .weN(weN), .oeN(oeN), .laneN(laneN),
    .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn),
    .memDin(memDin)
  );

  assign lbN    = laneN[0];
  assign ubN    = laneN[1];
  assign rdDone = strb.done;

  // cycles since output enable was last low, saturating at the gap
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  logic [GAP_W-1:0] sinceRd;
  always_ff @(posedge clk) begin
    if (rst)                               sinceRd <= GAP_W'(GAP_CYC);
    else if (!oeN)                         sinceRd <= '0;
    else if (sinceRd < GAP_W'(GAP_CYC))    sinceRd <= sinceRd + 1'b1;
  end

  // R8: the bus is never driven while the RAM may still be releasing it
  assert_float_gap_R8: assert property (@(posedge clk) disable iff (rst)
    memDoutEn |-> (sinceRd >= GAP_W'(GAP_CYC)));

  // R3: lane strobes never open on a read before output enable
  assert_lane_with_oe_R3: assert property (@(posedge clk) disable iff (rst)
    (weN && !(lbN && ubN)) |-> !oeN);

endmodule

// File: tb/sim_asram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_asram_lane_ctrl;

  localparam int CLK = 5;
  function automatic int cy(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int RD  = (cy(70) > cy(35)) ? cy(70) : cy(35);
  localparam int OE  = cy(35);
  localparam int WP  = (cy(35) > cy(30)) ? cy(35) : cy(30);
  localparam int WC  = cy(70);
  localparam int GAP = cy(30);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, hostValid, hostReady, hostWrite, rdDone;
  logic [18:0] hostAddr, memAddr;
  logic [15:0] hostWdata, rdData, memDout, memDin;
  logic [1:0]  hostMask;
  logic ce1N, ce2, weN, oeN, lbN, ubN, memDoutEn;

  asram_lane_ctrl u0 (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostReady(hostReady),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostMask(hostMask), .rdData(rdData), .rdDone(rdDone),
    .ce1N(ce1N), .ce2(ce2), .weN(weN), .oeN(oeN), .lbN(lbN), .ubN(ubN),
    .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // behavioural RAM, 256 words indexed by the low address byte
  logic [15:0] ram [256];
  wire rdSel = !ce1N && ce2 && weN && !oeN;
  assign memDin = { (rdSel && !ubN) ? ram[memAddr[7:0]][15:8] : 8'hA5,
                    (rdSel && !lbN) ? ram[memAddr[7:0]][7:0]  : 8'h5A };

  int checks = 0, failures = 0, cycles = 0;
  bit prevRead = 0;

  task automatic report(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", req, act, exp, cycles);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cycles++;
    if (!ce1N && ce2 && !weN) begin
      report("R6 bus driven during write", {31'b0, memDoutEn}, 32'd1);
      if (!lbN) ram[memAddr[7:0]][7:0]  = memDout[7:0];
      if (!ubN) ram[memAddr[7:0]][15:8] = memDout[15:8];
    end
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // expected pin vector: {ce1N,ce2,weN,oeN,ubN,lbN,memDoutEn,hostReady,rdDone}
  task automatic pins(input string req, input bit sel, input bit we, input bit oe,
                      input logic [1:0] lanes, input bit drv, input bit rdy, input bit dn);
    report(req, {23'b0, ce1N, ce2, weN, oeN, ubN, lbN, memDoutEn, hostReady, rdDone},
                {23'b0, !sel, sel, !we, !oe, !lanes[1], !lanes[0], drv, rdy, dn});
  endtask

  task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] m, input logic [15:0] expRd);
    int g, total;
    report("R2 ready before request", {31'b0, hostReady}, 32'd1);
    hostValid = 1; hostWrite = wr; hostAddr = a; hostWdata = d; hostMask = m;
    cyc();
    hostValid = 0; hostAddr = ~a; hostWdata = ~d;
    g = (wr && prevRead && m != 2'b00) ? GAP : 0;
    total = (m == 2'b00) ? 0 : (wr ? g + WC : RD);
    for (int t = 0; t <= total; t++) begin
      if (t > 0) cyc();
      if (t == total) begin
        pins(m == 0 ? "R9 empty mask done" : "R4 done pulse", 0, 0, 0, 2'b00, 0, 0, 1);
        if (!wr && m != 0) report("R4 read data lanes", {16'b0, rdData}, {16'b0, expRd});
      end else if (!wr) begin
        pins(t >= RD - OE ? "R3 read oe window" : "R2 read select", 1, 0, t >= RD - OE,
             (t >= RD - OE) ? m : 2'b00, 0, 0, 0);
        report("R2 read address", {13'b0, memAddr}, {13'b0, a});
      end else if (t < g) begin
        pins("R8 float gap", 0, 0, 0, 2'b00, 0, 0, 0);
      end else if (t < g + WP) begin
        pins("R5 write pulse", 1, 1, 0, m, 1, 0, 0);
        report("R7 write address", {13'b0, memAddr}, {13'b0, a});
        report("R6 write data", {16'b0, memDout}, {16'b0, d});
      end else begin
        pins("R5 write recovery", 0, 0, 0, 2'b00, 0, 0, 0);
      end
    end
    if (m != 2'b00) prevRead = !wr;
    cyc();
    pins("R4 ready after done", 0, 0, 0, 2'b00, 0, 1, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
    rst = 1; hostValid = 0; hostWrite = 0; hostAddr = '0; hostWdata = '0; hostMask = '0;
    repeat (3) cyc();
    rst = 0;
    cyc();
    pins("R1 reset state", 0, 0, 0, 2'b00, 0, 1, 0);
    report("R10 default counts", {RD[7:0], OE[7:0], WP[7:0], GAP[7:0]}, {8'd14, 8'd7, 8'd7, 8'd6});

    issue(1, 19'h12345, 16'hBEEF, 2'b11, 16'h0);      // R5 write, no gap after reset
    issue(0, 19'h12345, 16'h0,    2'b11, 16'hBEEF);   // R2 R3 R4 full read
    issue(1, 19'h00A07, 16'h1234, 2'b01, 16'h0);      // R8 gap, low lane only
    issue(0, 19'h00A07, 16'h0,    2'b11, 16'h0034);   // R4 high lane untouched
    issue(1, 19'h00A07, 16'hAB00, 2'b10, 16'h0);      // R8 gap, high lane only
    issue(0, 19'h00A07, 16'h0,    2'b01, 16'h0034);   // R4 unselected lane reads zero
    issue(1, 19'h00A07, 16'hFFFF, 2'b00, 16'h0);      // R9 empty write
    issue(1, 19'h00A07, 16'hFFFF, 2'b00, 16'h0);      // R9 gap still pending afterwards
    issue(0, 19'h00A07, 16'h0,    2'b10, 16'hAB00);   // R9 contents unchanged
    issue(0, 19'h7FF10, 16'h0,    2'b00, 16'h0);      // R9 empty read
    issue(1, 19'h7FF10, 16'h5A5A, 2'b11, 16'h0);      // R8 gap still required
    issue(1, 19'h7FF10, 16'hC3C3, 2'b11, 16'h0);      // R5 back-to-back write, no gap
    issue(0, 19'h7FF10, 16'h0,    2'b11, 16'hC3C3);   // R7 address change across ops
    issue(0, 19'h12345, 16'h0,    2'b10, 16'hBE00);   // R3 upper strobe only

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule